// File: doc/BRIEF.md
# Virtqueue Device Register File (legacy layout)

This block is the register front end of a paravirtual device seen through a small I/O window. A host-side access port reads and writes byte offsets. The common registers cover feature negotiation, queue selection, the queue base page number, queue size, queue notify, device status and interrupt status. When message-signalled interrupts are enabled, two interrupt-vector registers are added. Offsets at or beyond the common length go straight through to a device-specific configuration port, with the common length subtracted from the offset.

The block keeps a per-queue table of base page numbers and interrupt vectors. The device side can read any entry of this table through a separate index. The block drives three outputs towards the device: a level interrupt line, a one-cycle notify strobe that carries a queue number, and a one-cycle reset request. A zero page number or a zero status write clears all guest-visible state. Accesses are register-granular: each access names one register by its start offset. Read data is combinational, and side effects take place at the clock edge that ends the access.

Top module: `vq_regfile`

## Requirements
- R1: A read at offset 0 returns the device feature input with bits 24 (notify when empty), 28 (indirect descriptors) and 30 (negotiation-failure marker) forced to one.
- R2: A write at offset 4 stores the guest feature word. If bit 30 of the written value is set, the stored word is the fallback mask when `fallback_valid` is high, and zero otherwise.
- R3: A nonzero write at offset 8 stores the page number for the selected queue. Reads at offset 8 return the selected queue's page number. `dev_qbase` equals the indexed entry's page number shifted left by 12.
- R4: A zero write at offset 8, or a zero low byte written at offset 18, resets the device state. Status, guest features, ISR, queue select and every page number become zero, and every vector becomes 0xFFFF. `reset_req` is high for exactly the one cycle after the write.
- R5: A write at offset 14 changes the queue select only when the value is below NUM_QUEUES. Otherwise the old select is kept. Offset 14 reads the current select.
- R6: A write at offset 16 raises `notify_valid` for exactly the next cycle, with `notify_queue` equal to bits 15:0 of the written data.
- R7: A write at offset 18 keeps only bits 7:0 as the status. Reads at offset 18 return the status.
- R8: A read at offset 19 returns the ISR and clears it at the end of the access. ISR bits raised by `isr_set` in that same cycle are kept after the clear.
- R9: While `msix_en` is low, `irq_line` equals ISR bit 0. While `msix_en` is high, `irq_line` is low.
- R10: The common length is 20 bytes with `msix_en` low and 24 with it high. Accesses at or above that length assert `dcfg_valid`, present `dcfg_addr = acc_addr - length`, and return `dcfg_rdata`.
- R11: With `msix_en` high, writes at offset 20 (config vector) and offset 22 (selected queue's vector) store the data when `vec_ok` is high, and 0xFFFF when it is low. Both offsets read back their stored vectors.
- R12: Reads at common offsets that name no readable register (for example 1 and 16) return 0xFFFFFFFF. Offset 12 returns `dev_qsize` zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msix_en | input | 1 | Message-signalled interrupts enabled |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register offset in the window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational) |
| dcfg_valid | output | 1 | Access forwarded to the device-specific port |
| dcfg_write | output | 1 | Forwarded direction |
| dcfg_addr | output | ADDR_W | Offset within the device-specific region |
| dcfg_wdata | output | 32 | Forwarded write data |
| dcfg_rdata | input | 32 | Device-specific read data |
| dev_features | input | 32 | Device-supported feature mask |
| fallback_valid | input | 1 | A fallback feature mask exists |
| fallback_mask | input | 32 | Fallback feature mask |
| dev_qsize | input | 16 | Size of the selected queue |
| vec_ok | input | 1 | Vector allocation for the current write succeeded |
| isr_set | input | 8 | ISR bits to raise this cycle |
| dev_qidx | input | QW | Queue index for the device-side table read |
| sel_queue | output | QW | Currently selected queue |
| dev_qbase | output | PFN_W+PAGE_SHIFT | Base address of queue `dev_qidx` |
| dev_qvector | output | 16 | Vector of queue `dev_qidx` |
| dev_status | output | 8 | Device status |
| guest_features | output | 32 | Stored guest features |
| cfg_vector | output | 16 | Configuration-change vector |
| irq_line | output | 1 | Legacy level interrupt |
| notify_valid | output | 1 | One-cycle notify strobe |
| notify_queue | output | 16 | Queue number carried by the notify |
| reset_req | output | 1 | One-cycle device reset request |

## Verification
The bench builds the block with NUM_QUEUES = 4 and keeps the default 8-bit offset and 32-bit page-number widths. With only four queues, select values just at and above the limit can be tried cheaply. The reset check can then confirm that every entry of the page and vector tables is cleared, by sweeping the device-side index. Both values of `msix_en` are exercised, so the moving boundary at 20 or 24 bytes is tested from each side.

// File: rtl/vq_pkg.sv
package vq_pkg;
    // register start offsets (the host driver decodes these)
    localparam int unsigned OFF_HOSTF  = 0;
    localparam int unsigned OFF_GUESTF = 4;
    localparam int unsigned OFF_PFN    = 8;
    localparam int unsigned OFF_QSIZE  = 12;
    localparam int unsigned OFF_QSEL   = 14;
    localparam int unsigned OFF_NOTIFY = 16;
    localparam int unsigned OFF_STATUS = 18;
    localparam int unsigned OFF_ISR    = 19;
    localparam int unsigned OFF_CFGVEC = 20;
    localparam int unsigned OFF_QVEC   = 22;
    localparam int unsigned LEN_PLAIN  = 20;
    localparam int unsigned LEN_MSG    = 24;

    // capability bits merged into the host feature word
    localparam int unsigned FB_NOTIFY_EMPTY = 24;
    localparam int unsigned FB_INDIRECT     = 28;
    localparam int unsigned FB_BAD          = 30;

    localparam logic [15:0] NO_VECTOR = 16'hFFFF;
endpackage

// File: rtl/vq_queue_table.sv
module vq_queue_table #(
    parameter int NQ    = 64,
    parameter int PFN_W = 32,
    parameter int VEC_W = 16,
    localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_pfn_en,
    input  logic             wr_vec_en,
    input  logic [QW-1:0]    wr_idx,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic [VEC_W-1:0] wr_vec,
    input  logic [QW-1:0]    rd_idx_a,
    output logic [PFN_W-1:0] rd_pfn_a,
    output logic [VEC_W-1:0] rd_vec_a,
    input  logic [QW-1:0]    rd_idx_b,
    output logic [PFN_W-1:0] rd_pfn_b,
    output logic [VEC_W-1:0] rd_vec_b
);
    logic [PFN_W-1:0] pfn_q [NQ];
    logic [VEC_W-1:0] vec_q [NQ];

    for (genvar i = 0; i < NQ; i++) begin : g_entry
        logic [PFN_W-1:0] pfn_d;
        logic [VEC_W-1:0] vec_d;
        logic             hit;

        always_comb begin
            hit   = (wr_idx == QW'(i));
            pfn_d = pfn_q[i];
            vec_d = vec_q[i];
            if (clear) begin
                pfn_d = '0;
                vec_d = '1;
            end else begin
                if (wr_pfn_en && hit) pfn_d = wr_pfn;
                if (wr_vec_en && hit) vec_d = wr_vec;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pfn_q[i] <= '0;
                vec_q[i] <= '1;
            end else begin
                pfn_q[i] <= pfn_d;
                vec_q[i] <= vec_d;
            end
        end
    end

    assign rd_pfn_a = pfn_q[rd_idx_a];
    assign rd_vec_a = vec_q[rd_idx_a];
    assign rd_pfn_b = pfn_q[rd_idx_b];
    assign rd_vec_b = vec_q[rd_idx_b];
endmodule

// File: rtl/vq_isr_unit.sv
module vq_isr_unit #(
    parameter int ISR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             ack,
    input  logic [ISR_W-1:0] set,
    input  logic             msix_en,
    output logic [ISR_W-1:0] isr,
    output logic             irq_line
);
    logic [ISR_W-1:0] isr_d, isr_q;

    always_comb begin
        isr_d = (clear || ack) ? '0 : isr_q;
        isr_d = isr_d | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_d;
    end

    assign isr      = isr_q;
    assign irq_line = !msix_en && isr_q[0];

    // R8
    isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && set == '0) |=> (isr == '0));
endmodule

// File: rtl/vq_regfile.sv
module vq_regfile
    import vq_pkg::*;
#(
    parameter int NUM_QUEUES = 64,
    parameter int ADDR_W     = 8,
    parameter int PFN_W      = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int QW        = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
    localparam int BASE_W    = PFN_W + PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msix_en,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    output logic              dcfg_valid,
    output logic              dcfg_write,
    output logic [ADDR_W-1:0] dcfg_addr,
    output logic [31:0]       dcfg_wdata,
    input  logic [31:0]       dcfg_rdata,
    input  logic [31:0]       dev_features,
    input  logic              fallback_valid,
    input  logic [31:0]       fallback_mask,
    input  logic [15:0]       dev_qsize,
    input  logic              vec_ok,
    input  logic [7:0]        isr_set,
    input  logic [QW-1:0]     dev_qidx,
    output logic [QW-1:0]     sel_queue,
    output logic [BASE_W-1:0] dev_qbase,
    output logic [15:0]       dev_qvector,
    output logic [7:0]        dev_status,
    output logic [31:0]       guest_features,
    output logic [15:0]       cfg_vector,
    output logic              irq_line,
    output logic              notify_valid,
    output logic [15:0]       notify_queue,
    output logic              reset_req
);
    typedef struct packed {
        logic [31:0]   gfeat;
        logic [7:0]    status;
        logic [QW-1:0] qsel;
        logic [15:0]   cfg_vec;
        logic          notify_v;
        logic [15:0]   notify_q;
        logic          reset_req;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [ADDR_W-1:0] common_len;
    logic              in_common, wr_reg, rd_reg;
    logic              dev_reset, pfn_we, vec_we;
    logic [15:0]       vec_val;
    logic [PFN_W-1:0]  sel_pfn, b_pfn;
    logic [15:0]       sel_vec;
    logic [7:0]        isr_val;
    logic [31:0]       reg_rdata;

    assign common_len = msix_en ? ADDR_W'(LEN_MSG) : ADDR_W'(LEN_PLAIN);
    assign in_common  = acc_addr < common_len;
    assign wr_reg     = acc_valid && acc_write && in_common;
    assign rd_reg     = acc_valid && !acc_write && in_common;
    assign vec_val    = vec_ok ? acc_wdata[15:0] : NO_VECTOR;

    // device-specific pass-through
    assign dcfg_valid = acc_valid && !in_common;
    assign dcfg_write = acc_write;
    assign dcfg_addr  = acc_addr - common_len;
    assign dcfg_wdata = acc_wdata;

    always_comb begin
        regs_d           = regs_q;
        regs_d.notify_v  = 1'b0;
        regs_d.reset_req = 1'b0;
        dev_reset        = 1'b0;
        pfn_we           = 1'b0;
        vec_we           = 1'b0;
        if (wr_reg) begin
            case (acc_addr)
                ADDR_W'(OFF_GUESTF):
                    regs_d.gfeat = acc_wdata[FB_BAD]
                                 ? (fallback_valid ? fallback_mask : 32'h0)
                                 : acc_wdata;
                ADDR_W'(OFF_PFN):
                    if (acc_wdata == 32'h0) dev_reset = 1'b1;
                    else                    pfn_we    = 1'b1;
                ADDR_W'(OFF_QSEL):
                    if (acc_wdata < 32'(NUM_QUEUES)) regs_d.qsel = acc_wdata[QW-1:0];
                ADDR_W'(OFF_NOTIFY): begin
                    regs_d.notify_v = 1'b1;
                    regs_d.notify_q = acc_wdata[15:0];
                end
                ADDR_W'(OFF_STATUS): begin
                    regs_d.status = acc_wdata[7:0];
                    if (acc_wdata[7:0] == 8'h0) dev_reset = 1'b1;
                end
                ADDR_W'(OFF_CFGVEC): regs_d.cfg_vec = vec_val;
                ADDR_W'(OFF_QVEC):   vec_we = 1'b1;
                default: ;
            endcase
        end
        if (dev_reset) begin
            regs_d.gfeat     = '0;
            regs_d.status    = '0;
            regs_d.qsel      = '0;
            regs_d.cfg_vec   = NO_VECTOR;
            regs_d.reset_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q         <= '0;
            regs_q.cfg_vec <= NO_VECTOR;
        end else begin
            regs_q <= regs_d;
        end
    end

    vq_queue_table #(.NQ(NUM_QUEUES), .PFN_W(PFN_W), .VEC_W(16)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (dev_reset),
        .wr_pfn_en(pfn_we),
        .wr_vec_en(vec_we),
        .wr_idx   (regs_q.qsel),
        .wr_pfn   (PFN_W'(acc_wdata)),
        .wr_vec   (vec_val),
        .rd_idx_a (regs_q.qsel),
        .rd_pfn_a (sel_pfn),
        .rd_vec_a (sel_vec),
        .rd_idx_b (dev_qidx),
        .rd_pfn_b (b_pfn),
        .rd_vec_b (dev_qvector)
    );

    vq_isr_unit #(.ISR_W(8)) u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (dev_reset),
        .ack     (rd_reg && acc_addr == ADDR_W'(OFF_ISR)),
        .set     (isr_set),
        .msix_en (msix_en),
        .isr     (isr_val),
        .irq_line(irq_line)
    );

    always_comb begin
        reg_rdata = 32'hFFFF_FFFF;
        case (acc_addr)
            ADDR_W'(OFF_HOSTF):  reg_rdata = dev_features | (32'h1 << FB_NOTIFY_EMPTY)
                                           | (32'h1 << FB_INDIRECT) | (32'h1 << FB_BAD);
            ADDR_W'(OFF_GUESTF): reg_rdata = regs_q.gfeat;
            ADDR_W'(OFF_PFN):    reg_rdata = 32'(sel_pfn);
            ADDR_W'(OFF_QSIZE):  reg_rdata = {16'h0, dev_qsize};
            ADDR_W'(OFF_QSEL):   reg_rdata = 32'(regs_q.qsel);
            ADDR_W'(OFF_STATUS): reg_rdata = {24'h0, regs_q.status};
            ADDR_W'(OFF_ISR):    reg_rdata = {24'h0, isr_val};
            ADDR_W'(OFF_CFGVEC): reg_rdata = {16'h0, regs_q.cfg_vec};
            ADDR_W'(OFF_QVEC):   reg_rdata = {16'h0, sel_vec};
            default: ;
        endcase
    end

    assign acc_rdata      = in_common ? reg_rdata : dcfg_rdata;
    assign sel_queue      = regs_q.qsel;
    assign dev_qbase      = {b_pfn, {PAGE_SHIFT{1'b0}}};
    assign dev_status     = regs_q.status;
    assign guest_features = regs_q.gfeat;
    assign cfg_vector     = regs_q.cfg_vec;
    assign notify_valid   = regs_q.notify_v;
    assign notify_queue   = regs_q.notify_q;
    assign reset_req      = regs_q.reset_req;

    // R6
    notify_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> $past(acc_valid && acc_write && acc_addr == ADDR_W'(OFF_NOTIFY)));

    // R5
    qsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && acc_addr == ADDR_W'(OFF_QSEL) && acc_wdata >= 32'(NUM_QUEUES))
        |=> $stable(sel_queue));

    // R11
    vec_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && acc_addr == ADDR_W'(OFF_CFGVEC) && !vec_ok) |=> (cfg_vector == NO_VECTOR));

    // R4
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (dev_status == 8'h0 && guest_features == 32'h0
                       && cfg_vector == NO_VECTOR && !irq_line));
endmodule

// File: tb/tb_vq_regfile.sv
module tb_vq_regfile;
    localparam int NQ     = 4;
    localparam int AW     = 8;
    localparam int QW     = 2;
    localparam int BASE_W = 44;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              msix_en = 1'b0;
    logic              acc_valid = 1'b0, acc_write = 1'b0;
    logic [AW-1:0]     acc_addr = '0;
    logic [31:0]       acc_wdata = '0, acc_rdata;
    logic              dcfg_valid, dcfg_write;
    logic [AW-1:0]     dcfg_addr;
    logic [31:0]       dcfg_wdata;
    logic [31:0]       dcfg_rdata = 32'h0000_CAFE;
    logic [31:0]       dev_features = 32'h0000_00A5;
    logic              fallback_valid = 1'b0;
    logic [31:0]       fallback_mask = 32'h77;
    logic [15:0]       dev_qsize = 16'h0100;
    logic              vec_ok = 1'b1;
    logic [7:0]        isr_set = '0;
    logic [QW-1:0]     dev_qidx = '0;
    logic [QW-1:0]     sel_queue;
    logic [BASE_W-1:0] dev_qbase;
    logic [15:0]       dev_qvector, cfg_vector, notify_queue;
    logic [7:0]        dev_status;
    logic [31:0]       guest_features;
    logic              irq_line, notify_valid, reset_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vq_regfile #(.NUM_QUEUES(NQ)) dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = AW'(a); acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = AW'(a);
        #1 d = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic pulse_isr(input logic [7:0] v);
        @(negedge clk);
        isr_set = v;
        @(negedge clk);
        isr_set = '0;
    endtask

    task automatic t_reset_state();
        chk("R4 reset status", dev_status, 0);
        chk("R4 reset features", guest_features, 0);
        chk("R4 reset cfg vector", cfg_vector, 16'hFFFF);
        chk("R9 reset irq", irq_line, 0);
        chk("R6 reset notify", notify_valid, 0);
    endtask

    task automatic t_features();
        logic [31:0] d;
        rd(0, d);
        chk("R1 host features", d, 32'h5100_00A5);
        wr(4, 32'h3);
        rd(4, d);
        chk("R2 guest features plain", d, 32'h3);
        fallback_valid = 1'b1;
        wr(4, 32'h4000_0001);
        chk("R2 fallback mask", guest_features, 32'h77);
        fallback_valid = 1'b0;
        wr(4, 32'h4000_0001);
        chk("R2 no fallback", guest_features, 0);
    endtask

    task automatic t_queue();
        logic [31:0] d;
        wr(14, 2);
        wr(8, 32'h1234);
        rd(8, d);
        chk("R3 pfn readback", d, 32'h1234);
        dev_qidx = 2'd2;
        #1 chk("R3 base address", dev_qbase, 64'h123_4000);
        wr(14, 1);
        rd(8, d);
        chk("R3 other queue pfn", d, 0);
        wr(14, 4);
        chk("R5 select at limit ignored", sel_queue, 1);
        wr(14, 9);
        rd(14, d);
        chk("R5 select above limit ignored", d, 1);
        rd(12, d);
        chk("R12 queue size", d, 32'h100);
    endtask

    task automatic t_notify();
        wr(16, 32'h0003_0005);
        chk("R6 notify strobe", notify_valid, 1);
        chk("R6 notify queue", notify_queue, 5);
        @(negedge clk);
        chk("R6 notify one cycle", notify_valid, 0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        wr(18, 32'h1F7);
        rd(18, d);
        chk("R7 status low byte", d, 32'hF7);
        chk("R4 no reset on nonzero status", reset_req, 0);
    endtask

    task automatic t_isr();
        logic [31:0] d;
        msix_en = 1'b0;
        pulse_isr(8'h03);
        chk("R9 irq follows bit0", irq_line, 1);
        rd(19, d);
        chk("R8 isr read value", d, 3);
        chk("R8 irq dropped after read", irq_line, 0);
        rd(19, d);
        chk("R8 isr cleared", d, 0);
        pulse_isr(8'h01);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = AW'(19); isr_set = 8'h04;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0; isr_set = '0;
        chk("R8 read with set returns old", d, 1);
        rd(19, d);
        chk("R8 concurrent set kept", d, 4);
    endtask

    task automatic t_msix();
        logic [31:0] d;
        msix_en = 1'b1;
        pulse_isr(8'h01);
        chk("R9 irq low with msix", irq_line, 0);
        rd(19, d);
        vec_ok = 1'b1;
        wr(20, 7);
        rd(20, d);
        chk("R11 cfg vector stored", d, 7);
        wr(22, 32'h0012);
        rd(22, d);
        chk("R11 queue vector stored", d, 32'h12);
        vec_ok = 1'b0;
        wr(20, 9);
        chk("R11 cfg vector fail", cfg_vector, 16'hFFFF);
        vec_ok = 1'b1;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = AW'(24);
        #1;
        chk("R10 msix pass valid", dcfg_valid, 1);
        chk("R10 msix pass addr", dcfg_addr, 0);
        chk("R10 msix pass data", acc_rdata, 32'hCAFE);
        msix_en = 1'b0;
        acc_addr = AW'(20);
        #1;
        chk("R10 plain pass addr", dcfg_addr, 0);
        chk("R10 plain pass data", acc_rdata, 32'hCAFE);
        acc_addr = AW'(24);
        #1 chk("R10 plain pass addr 24", dcfg_addr, 4);
        acc_addr = AW'(19);
        #1 chk("R10 common not forwarded", dcfg_valid, 0);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(1, d);
        chk("R12 unmapped offset 1", d, 32'hFFFF_FFFF);
        rd(16, d);
        chk("R12 notify not readable", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_dev_reset();
        logic [31:0] d;
        msix_en = 1'b1;
        wr(14, 2);
        wr(22, 32'h21);
        wr(4, 32'h5);
        wr(18, 32'h0F);
        pulse_isr(8'h02);
        wr(8, 0);
        chk("R4 reset pulse", reset_req, 1);
        chk("R4 status cleared", dev_status, 0);
        chk("R4 features cleared", guest_features, 0);
        chk("R4 select cleared", sel_queue, 0);
        @(negedge clk);
        chk("R4 reset one cycle", reset_req, 0);
        for (int i = 0; i < NQ; i++) begin
            dev_qidx = QW'(i);
            #1;
            chk("R4 table base cleared", dev_qbase, 0);
            chk("R4 table vector cleared", dev_qvector, 16'hFFFF);
        end
        rd(19, d);
        chk("R4 isr cleared", d, 0);
        wr(18, 32'h3);
        wr(18, 32'h100);
        chk("R4 status zero reset pulse", reset_req, 1);
        msix_en = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset_state();
                t_features();
                t_queue();
                t_notify();
                t_status();
                t_isr();
                t_msix();
                t_unmapped();
                t_dev_reset();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule